// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column address of a synchronous DRAM burst, one beat per clock. A controller raises `cmd_start` together with a start column, a burst length code and a burst ordering. From the next clock the block presents one column per cycle with `beat_valid` high. It flags the final beat of a fixed-length burst with `last_beat`. The burst ends at its programmed length, on a `stop` pulse (used for both a burst-stop and a precharge command), or when a new `cmd_start` replaces it.

Two orderings are supported. Sequential ordering counts upward and wraps inside the aligned block of the burst length. Interleaved ordering XORs the beat number into the low bits of the start column. The full-page code runs through every column of the row and wraps back to the start column, with no end until it is stopped. Interleaving is not defined for that code, so a full-page burst always counts sequentially. While `cke` is low the block is suspended: nothing advances and no command is taken.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset the block is idle, with `beat_valid`, `last_beat` and `col` all zero.
- R2: `bl_code` 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. `beat_valid` is high from the cycle after the accepting edge for exactly that many unsuspended cycles.
- R3: With `burst_type` 0 (sequential), beat i presents the start column with its low log2(BL) bits replaced by (start + i) mod BL. The upper bits are unchanged.
- R4: With `burst_type` 1 (interleaved), beat i presents the start column with its low log2(BL) bits XORed with i.
- R5: `bl_code` 7 selects full page. Beat i presents (start + i) mod 2^COL_W and wraps back to the start column after 2^COL_W beats. The burst never ends by itself, and `burst_type` is ignored.
- R6: `last_beat` is high only on the final beat of a fixed-length burst. With length 1 it is high on the first beat, and it is never high in full-page mode.
- R7: A `stop` pulse accepted while `cke` is high ends the burst: no beat is presented after that edge.
- R8: A `cmd_start` accepted during a burst discards it. The new burst presents its own start column in the next cycle.
- R9: While `cke` is low the outputs hold their values and `cmd_start` and `stop` are ignored.
- R10: The reserved `bl_code` values 4, 5 and 6 behave as a burst of length 1.
- R11: When `cmd_start` and `stop` are both high in an accepted cycle, the new burst starts.
- R12: `col` reads zero whenever `beat_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low suspends the block |
| cmd_start | input | 1 | Read or write command: begin a new burst |
| start_col | input | COL_W | Start column of the new burst |
| bl_code | input | 3 | Burst length code (0..3 = 1/2/4/8, 7 = full page) |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | Burst-stop or precharge: end the running burst |
| col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | This beat is the final one of the burst |

## Verification
The bench builds the block with the default COL_W of 8. This makes a full-page burst 256 beats long, so a single run can pass a complete wrap back to the start column and keep going, which checks that full page never flags an end. At this width all four fixed lengths and both orderings fit inside the column, with start columns placed off the block boundary to expose the in-block wrap. The bench also applies suspension with pending commands, replacement mid-burst, stops, a simultaneous start and stop, and a reserved code.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic {
        BT_SEQ = 1'b0,
        BT_ILV = 1'b1
    } burst_order_e;

    localparam logic [2:0] BLC_ONE   = 3'd0;
    localparam logic [2:0] BLC_TWO   = 3'd1;
    localparam logic [2:0] BLC_FOUR  = 3'd2;
    localparam logic [2:0] BLC_EIGHT = 3'd3;
    localparam logic [2:0] BLC_PAGE  = 3'd7;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code,
    output logic [COL_W-1:0] wrap_mask,
    output logic             page
);
    localparam int MASK_W = COL_W;

    always_comb begin
        wrap_mask = '0;
        page      = 1'b0;
        case (code)
            BLC_TWO:   wrap_mask = MASK_W'(1);
            BLC_FOUR:  wrap_mask = MASK_W'(3);
            BLC_EIGHT: wrap_mask = MASK_W'(7);
            BLC_PAGE: begin
                wrap_mask = '1;
                page      = 1'b1;
            end
            default:   wrap_mask = '0;
        endcase
    end

endmodule

// File: rtl/bcg_beat_addr.sv
module bcg_beat_addr #(
    parameter int COL_W = 8
) (
    input  logic             en,
    input  logic             interleave,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] mixed;

    assign sum = base + beat;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!wrap_mask[b])
                mixed[b] = base[b];
            else if (interleave)
                mixed[b] = base[b] ^ beat[b];
            else
                mixed[b] = sum[b];
        end
    end

    assign col = en ? mixed : '0;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             burst_type,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             beat_valid,
    output logic             last_beat
);
    typedef struct packed {
        logic             active;
        logic             page;
        logic             interleave;
        logic [COL_W-1:0] wrap_mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
    } walk_t;

    walk_t            walk_d, walk_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             final_beat;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code      (bl_code),
        .wrap_mask (dec_mask),
        .page      (dec_page)
    );

    bcg_beat_addr #(.COL_W(COL_W)) u_addr (
        .en         (walk_q.active),
        .interleave (walk_q.interleave),
        .base       (walk_q.base),
        .beat       (walk_q.beat),
        .wrap_mask  (walk_q.wrap_mask),
        .col        (col)
    );

    assign final_beat = walk_q.active && !walk_q.page && (walk_q.beat == walk_q.wrap_mask);

    always_comb begin
        walk_d = walk_q;
        if (cke) begin
            if (cmd_start) begin
                walk_d.active     = 1'b1;
                walk_d.page       = dec_page;
                walk_d.interleave = (burst_type == BT_ILV) && !dec_page;
                walk_d.wrap_mask  = dec_mask;
                walk_d.base       = start_col;
                walk_d.beat       = '0;
            end else if (stop) begin
                walk_d.active = 1'b0;
            end else if (walk_q.active) begin
                if (final_beat)
                    walk_d.active = 1'b0;
                else
                    walk_d.beat = walk_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            walk_q <= '0;
        else
            walk_q <= walk_d;
    end

    assign beat_valid = walk_q.active;
    assign last_beat  = final_beat;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cmd_start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic [COL_W-1:0] col,
    input logic             beat_valid,
    input logic             last_beat
);
    p_last_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    p_idle_col_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> col == '0);

    p_suspend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(col) && $stable(beat_valid) && $stable(last_beat));

    p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cke && stop && !cmd_start |=> !beat_valid);

    p_start_first_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cke && cmd_start |=> beat_valid && col == $past(start_col));

    p_last_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke && last_beat && !cmd_start |=> !beat_valid);

endmodule

bind sdram_burst_colgen bcg_checker #(.COL_W(COL_W)) u_bcg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cmd_start  (cmd_start),
    .start_col  (start_col),
    .stop       (stop),
    .col        (col),
    .beat_valid (beat_valid),
    .last_beat  (last_beat)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;
    localparam int PAGE_LEN   = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cke = 1'b1;
    logic             cmd_start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       bl_code = '0;
    logic             burst_type = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col;
    logic             beat_valid;
    logic             last_beat;

    typedef struct {
        logic       v;
        logic [7:0] c;
        logic       l;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    int m_act = 0, m_base = 0, m_i = 0, m_len = 1, m_full = 0, m_il = 0;

    sdram_burst_colgen #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_start(cmd_start),
        .start_col(start_col), .bl_code(bl_code), .burst_type(burst_type),
        .stop(stop), .col(col), .beat_valid(beat_valid), .last_beat(last_beat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_col();
        int blk, off;
        if (!m_act) return 0;
        if (m_full) return (m_base + m_i) % PAGE_LEN;
        blk = m_base - (m_base % m_len);
        off = m_base % m_len;
        if (m_il) return blk + (off ^ m_i);
        return blk + ((off + m_i) % m_len);
    endfunction

    task automatic cyc(input logic k, input logic st, input logic [7:0] sc,
                       input logic [2:0] code, input logic ty, input logic sp,
                       input string tag);
        exp_t e;
        @(negedge clk);
        cke = k; cmd_start = st; start_col = sc; bl_code = code;
        burst_type = ty; stop = sp;
        if (k) begin
            if (st) begin
                m_act = 1; m_base = int'(sc); m_i = 0;
                if (code == 3'd7) begin
                    m_full = 1; m_len = PAGE_LEN; m_il = 0;
                end else begin
                    m_full = 0; m_len = (code < 3'd4) ? (1 << code) : 1; m_il = int'(ty);
                end
            end else if (sp) begin
                m_act = 0;
            end else if (m_act != 0) begin
                if (!m_full && m_i == m_len - 1) m_act = 0;
                else m_i = (m_i + 1) % PAGE_LEN;
            end
        end
        e.v = (m_act != 0);
        e.c = 8'(model_col());
        e.l = (m_act != 0) && !m_full && (m_i == m_len - 1);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int j = 0; j < n; j++) cyc(1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic go(input logic [7:0] sc, input logic [2:0] code, input logic ty, input string tag);
        cyc(1, 1, sc, code, ty, 0, tag);
    endtask

    // monitor: compare one expected record per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (beat_valid !== e.v || col !== e.c || last_beat !== e.l) begin
                    n_fail++;
                    $display("FAIL %s: valid/col/last = %0b/%0h/%0b expected %0b/%0h/%0b",
                             e.tag, beat_valid, col, last_beat, e.v, e.c, e.l);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        n_checks++;
        if (beat_valid !== 1'b0 || last_beat !== 1'b0 || col !== '0) begin
            n_fail++;
            $display("FAIL R1: valid/col/last = %0b/%0h/%0b expected 0/0/0", beat_valid, col, last_beat);
        end
        idle(2, "R12");

        // R3 R2 R6: sequential length 4, start mid-block
        go(8'h06, 3'd2, 1'b0, "R3");
        idle(5, "R3");
        // R4: interleaved length 8
        go(8'h2D, 3'd3, 1'b1, "R4");
        idle(9, "R4");
        // R3: sequential length 8 crossing block end
        go(8'h5E, 3'd3, 1'b0, "R3");
        idle(9, "R3");
        // R6 R2: length 1 and length 2 both orders
        go(8'h41, 3'd0, 1'b0, "R6");
        idle(2, "R6");
        go(8'h13, 3'd1, 1'b0, "R2");
        idle(3, "R2");
        go(8'h13, 3'd1, 1'b1, "R4");
        idle(3, "R4");
        // R10: reserved code
        go(8'h77, 3'd5, 1'b0, "R10");
        idle(2, "R10");
        // R5: full page with interleave request, past the wrap
        go(8'hF0, 3'd7, 1'b1, "R5");
        for (int j = 0; j < PAGE_LEN + 4; j++) cyc(1, 0, 0, 3'd7, 1'b1, 0, "R5");
        cyc(1, 0, 0, 0, 0, 1, "R7");
        idle(2, "R7");
        // R9: suspend with commands pending
        go(8'h31, 3'd3, 1'b0, "R9");
        idle(2, "R9");
        cyc(0, 0, 0, 0, 0, 0, "R9");
        cyc(0, 1, 8'hAA, 3'd2, 1'b0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 1, "R9");
        idle(7, "R9");
        // R8: replacement mid-burst
        go(8'h88, 3'd3, 1'b0, "R8");
        idle(2, "R8");
        go(8'hC6, 3'd2, 1'b1, "R8");
        idle(5, "R8");
        // R7: stop during length 8
        go(8'h20, 3'd3, 1'b0, "R7");
        idle(1, "R7");
        cyc(1, 0, 0, 0, 0, 1, "R7");
        idle(2, "R7");
        // R11: start and stop together
        go(8'h50, 3'd3, 1'b0, "R11");
        cyc(1, 1, 8'h93, 3'd2, 1'b0, 1, "R11");
        idle(5, "R11");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule